// File: doc/BRIEF.md
# Seek and Disk-Change Tracker

This block keeps the present cylinder of one drive head and turns seek requests into a train of step pulses with a direction level. A request carries a mode and an argument. The mode is an absolute move to a cylinder, a relative move inward by a count, or a relative move outward by a count. The block works out the destination once, clamped to the legal cylinder range. It then steps one cylinder per pulse until it gets there, and raises a single-cycle completion pulse. The controller around it uses that pulse to raise its interrupt.

The block also holds the disk-change flag that the host sees as bit 7 of its digital input register. The flag is set at reset and whenever no medium is in the drive. It is cleared only when a real step pulse starts while a medium is present. Inserting a medium does not clear it. Neither does a seek to the cylinder already held, and host reads of the flag have no effect on it.

The sequencer has four named states. IDLE accepts a request. PULSE holds the step output high. GAP holds it low between pulses. DONE raises the completion pulse. The transitions are:
- IDLE to DONE when the destination equals the present cylinder.
- IDLE to PULSE otherwise.
- PULSE to GAP when the pulse ends short of the destination.
- PULSE to DONE when the pulse ends on the destination.
- GAP to PULSE when the gap time has elapsed.
- DONE to IDLE always.

Top module: `seek_tracker`

## Requirements
- R1: After reset, pcn is 0, dskchg is 1, step and seek_done are 0, and ready is 1.
- R2: seek_mode 2'b00 (and 2'b11) is an absolute seek: the final pcn equals seek_arg, clamped to MAX_CYL.
- R3: seek_mode 2'b01 is a relative seek inward: the final pcn is pcn + seek_arg, saturating at MAX_CYL.
- R4: seek_mode 2'b10 is a relative seek outward: the final pcn is pcn - seek_arg, saturating at 0.
- R5: A seek emits exactly |destination - pcn| step pulses, each high for STEP_HI cycles. step_dir is 1 during every pulse of an increasing seek and 0 during every pulse of a decreasing one. pcn changes by exactly one per pulse.
- R6: seek_done is a one-cycle pulse. It comes in the cycle after the last step pulse ends, or in the cycle after a zero-distance request. ready is low while a seek runs, and seek_req is ignored during that time.
- R7: dskchg is 1 whenever media_present is 0 (one cycle after it falls), including across seeks made without a medium.
- R8: Inserting a medium, a zero-distance seek and any number of reads of dskchg leave dskchg unchanged.
- R9: dskchg falls to 0 exactly when a step pulse starts while media_present is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seek_req | input | 1 | Seek request, taken when ready is 1 |
| seek_mode | input | 2 | 00/11 absolute, 01 inward, 10 outward |
| seek_arg | input | CYL_W | Destination cylinder or relative count |
| media_present | input | 1 | 1 while a medium is in the drive |
| ready | output | 1 | Sequencer idle and able to take a request |
| pcn | output | CYL_W | Present cylinder number |
| step | output | 1 | Step pulse to the drive |
| step_dir | output | 1 | 1 = inward (cylinder increasing) |
| seek_done | output | 1 | One-cycle seek completion pulse |
| dskchg | output | 1 | Disk-change flag, host bit 7 |

## Verification
The bench builds the block with MAX_CYL of 20, STEP_HI of 2 and STEP_LO of 1, with CYL_W left at 8. Random 8-bit arguments therefore overshoot the cylinder range most of the time. Both saturation limits are hit often, and even full-range seeks stay short. The one-cycle gap makes back-to-back pulses and the PULSE-to-DONE hand-off occur many times. Random media removal and insertion between seeks sets the flag again and again, and the bench checks which later seeks may clear it.

// File: rtl/seek_pkg.sv
package seek_pkg;

    typedef enum logic [1:0] {
        MODE_ABS     = 2'b00,
        MODE_INWARD  = 2'b01,
        MODE_OUTWARD = 2'b10,
        MODE_ABS_ALT = 2'b11
    } seek_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/seek_target_calc.sv
module seek_target_calc
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  logic [1:0]       mode,
    input  logic [CYL_W-1:0] arg,
    input  logic [CYL_W-1:0] cur,
    output logic [CYL_W-1:0] target
);
    localparam logic [CYL_W:0] LIMIT = (CYL_W+1)'(MAX_CYL);

    logic [CYL_W:0] sum_w;
    logic [CYL_W:0] arg_w;

    always_comb begin
        sum_w = {1'b0, cur} + {1'b0, arg};
        arg_w = {1'b0, arg};
        unique case (seek_mode_e'(mode))
            MODE_INWARD:  target = (sum_w > LIMIT) ? LIMIT[CYL_W-1:0] : sum_w[CYL_W-1:0];
            MODE_OUTWARD: target = (arg > cur) ? '0 : (cur - arg);
            MODE_ABS,
            MODE_ABS_ALT: target = (arg_w > LIMIT) ? LIMIT[CYL_W-1:0] : arg;
            default:      target = cur;
        endcase
    end

    always_comb begin
        if (cur <= LIMIT[CYL_W-1:0]) begin
            AST_TARGET_RANGE: assert (target <= LIMIT[CYL_W-1:0]); // R2
        end
    end

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int STEP_HI = 2,
    parameter int STEP_LO = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CYL_W-1:0] target,
    output logic [CYL_W-1:0] pcn,
    output logic             step,
    output logic             step_dir,
    output logic             seek_done,
    output logic             ready,
    output logic             step_start
);
    localparam int SPAN  = (STEP_HI > STEP_LO) ? STEP_HI : STEP_LO;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(STEP_HI - 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(STEP_LO - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CYL_W-1:0] tgt_q, tgt_d;
    logic [CYL_W-1:0] pcn_q, pcn_d;
    logic             dir_q, dir_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            pcn_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tgt_q   <= tgt_d;
            pcn_q   <= pcn_d;
            dir_q   <= dir_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        tgt_d      = tgt_q;
        pcn_d      = pcn_q;
        dir_d      = dir_q;
        step_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    tgt_d = target;
                    if (target == pcn_q) begin
                        state_d = ST_DONE;
                    end else begin
                        dir_d      = (target > pcn_q);
                        cnt_d      = '0;
                        step_start = 1'b1;
                        state_d    = ST_PULSE;
                    end
                end
            end
            ST_PULSE: begin
                if (cnt_q == HI_LAST) begin
                    pcn_d   = dir_q ? (pcn_q + 1'b1) : (pcn_q - 1'b1);
                    cnt_d   = '0;
                    state_d = (pcn_d == tgt_q) ? ST_DONE : ST_GAP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_q == LO_LAST) begin
                    cnt_d      = '0;
                    step_start = 1'b1;
                    state_d    = ST_PULSE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pcn       = pcn_q;
        step_dir  = dir_q;
        step      = (state_q == ST_PULSE);
        seek_done = (state_q == ST_DONE);
        ready     = (state_q == ST_IDLE);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done |=> !seek_done); // R6
    AST_PCN_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pcn) |-> $past(step)); // R5
    AST_PCN_UNIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pcn) && $past(step_dir)) |-> (pcn == $past(pcn) + 1'b1)); // R5
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(step)) |-> $stable(step_dir)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !ready); // R6

endmodule

// File: rtl/dskchg_latch.sv
module dskchg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic media_present,
    input  logic step_start,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b1;
        else if (!media_present) flag <= 1'b1;
        else if (step_start)     flag <= 1'b0;
    end

    AST_NO_MEDIA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !media_present |=> flag); // R7
    AST_CLEAR_NEEDS_MEDIA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(media_present)); // R9

endmodule

// File: rtl/seek_tracker.sv
module seek_tracker
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79,
    parameter int STEP_HI = 2,
    parameter int STEP_LO = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seek_req,
    input  logic [1:0]       seek_mode,
    input  logic [CYL_W-1:0] seek_arg,
    input  logic             media_present,
    output logic             ready,
    output logic [CYL_W-1:0] pcn,
    output logic             step,
    output logic             step_dir,
    output logic             seek_done,
    output logic             dskchg
);
    logic [CYL_W-1:0] target;
    logic             step_start;

    seek_target_calc #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_calc (
        .mode   (seek_mode),
        .arg    (seek_arg),
        .cur    (pcn),
        .target (target)
    );

    step_sequencer #(.CYL_W(CYL_W), .STEP_HI(STEP_HI), .STEP_LO(STEP_LO)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seek_req),
        .target     (target),
        .pcn        (pcn),
        .step       (step),
        .step_dir   (step_dir),
        .seek_done  (seek_done),
        .ready      (ready),
        .step_start (step_start)
    );

    dskchg_latch u_chg (
        .clk           (clk),
        .rst_n         (rst_n),
        .media_present (media_present),
        .step_start    (step_start),
        .flag          (dskchg)
    );

    AST_PCN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pcn <= CYL_W'(MAX_CYL)); // R3
    AST_CHG_CLEAR_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dskchg) |-> $rose(step)); // R9
    AST_DONE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seek_done |-> !step); // R6

endmodule

// File: tb/tb_seek_tracker.sv
module tb_seek_tracker;
    localparam int CW  = 8;
    localparam int MAX = 20;
    localparam int HI  = 2;
    localparam int LO  = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seek_req = 1'b0;
    logic [1:0]    seek_mode = 2'b00;
    logic [CW-1:0] seek_arg = '0;
    logic          media_present = 1'b0;
    logic          ready, step, step_dir, seek_done, dskchg;
    logic [CW-1:0] pcn;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int hi_len = 0;
    logic step_prev = 1'b0;
    logic exp_dir = 1'b0;
    logic mon_on = 1'b0;
    int exp_pcn = 0;
    logic exp_chg = 1'b1;

    always #5 clk = ~clk;

    seek_tracker #(.CYL_W(CW), .MAX_CYL(MAX), .STEP_HI(HI), .STEP_LO(LO)) dut (
        .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_mode(seek_mode),
        .seek_arg(seek_arg), .media_present(media_present), .ready(ready),
        .pcn(pcn), .step(step), .step_dir(step_dir), .seek_done(seek_done),
        .dskchg(dskchg)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_dest(input int mode, input int arg, input int cur);
        int r;
        if (mode == 1)      r = (cur + arg > MAX) ? MAX : cur + arg;
        else if (mode == 2) r = (arg > cur) ? 0 : cur - arg;
        else                r = (arg > MAX) ? MAX : arg;
        return r;
    endfunction

    // pulse monitor (R5)
    always @(negedge clk) begin
        if (mon_on) begin
            if (step && !step_prev) rises++;
            if (step) begin
                hi_len++;
                check("R5 dir", int'(step_dir), int'(exp_dir));
            end
            if (!step && step_prev) begin
                check("R5 width", hi_len, HI);
                hi_len = 0;
            end
        end
        step_prev = step;
    end

    task automatic do_seek(input int mode, input int arg, input bit busy_poke);
        int dest, waits;
        dest = model_dest(mode, arg, exp_pcn);
        exp_dir = (dest > exp_pcn);
        rises = 0;
        @(negedge clk);
        seek_req = 1'b1; seek_mode = 2'(mode); seek_arg = CW'(arg);
        @(negedge clk);
        seek_req = 1'b0;
        waits = 1;
        if (busy_poke && !seek_done) begin
            seek_req = 1'b1; seek_mode = 2'b00; seek_arg = CW'((dest + 5) % (MAX + 1));
            @(negedge clk);
            seek_req = 1'b0;
            waits++;
        end
        while (!seek_done && waits < 3000) begin
            @(negedge clk);
            waits++;
        end
        check("R6 done seen", int'(seek_done), 1);
        if (dest == exp_pcn) check("R6 zero-distance latency", waits, 1);
        check(mode == 1 ? "R3 pcn" : (mode == 2 ? "R4 pcn" : "R2 pcn"), int'(pcn), dest);
        check("R5 step count", rises, (dest > exp_pcn) ? dest - exp_pcn : exp_pcn - dest);
        if (!media_present) exp_chg = 1'b1;
        else if (dest != exp_pcn) exp_chg = 1'b0;
        check("R8/R9 dskchg after seek", int'(dskchg), int'(exp_chg));
        exp_pcn = dest;
        @(negedge clk);
        check("R6 done single", int'(seek_done), 0);
        check("R6 ready", int'(ready), 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pcn", int'(pcn), 0);
        check("R1 dskchg", int'(dskchg), 1);
        check("R1 step", int'(step), 0);
        check("R1 done", int'(seek_done), 0);
        check("R1 ready", int'(ready), 1);
        mon_on = 1'b1;

        repeat (4) begin
            @(negedge clk);
            check("R7 no media reads", int'(dskchg), 1);
        end
        do_seek(0, 1, 0);                      // R7 seek without media
        media_present = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 insert keeps flag", int'(dskchg), 1);
        do_seek(0, 1, 0);                      // R8 zero distance
        check("R8 zero-distance keeps flag", int'(dskchg), 1);
        do_seek(1, 3, 0);                      // R9, R3
        check("R9 cleared", int'(dskchg), 0);
        repeat (3) @(negedge clk);
        check("R8 reads keep clear", int'(dskchg), 0);
        media_present = 1'b0;
        @(negedge clk);
        check("R7 eject sets", int'(dskchg), 1);
        exp_chg = 1'b1;
        media_present = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reads keep set", int'(dskchg), 1);
        do_seek(2, 10, 0);                     // R4 underflow to 0
        do_seek(1, 30, 0);                     // R3 overflow to MAX
        do_seek(3, 200, 0);                    // R2 alternate encoding, clamp
        do_seek(0, 0, 1);                      // R6 request while busy ignored
        do_seek(1, 255, 0);                    // R3 largest count

        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(3) == 0) begin
                media_present = ~media_present;
                @(negedge clk);
                if (!media_present) begin
                    exp_chg = 1'b1;
                    check("R7 random eject", int'(dskchg), 1);
                end else begin
                    check("R8 random insert", int'(dskchg), int'(exp_chg));
                end
            end
            do_seek(int'($urandom_range(3)),
                    ($urandom_range(1) == 0) ? int'($urandom_range(255)) : int'($urandom_range(6)),
                    $urandom_range(4) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule